// File: doc/BRIEF.md
# Guard-Bit Multiply-Accumulate Unit

This block multiplies two 16-bit operands once per clock cycle and folds the product into a 40-bit accumulator register. An operation is taken when the valid input is high. The opcode chooses one of four actions: load the product into the accumulator, add the product to it, subtract the product from it, or clear it. Per operation, the operands and the accumulator can be read as two's complement or as unsigned. Eight guard bits above the 32-bit product width let long sums run without wrapping. When saturation is selected, a sum that leaves the 40-bit range clamps to the nearest limit instead of wrapping.

Two extracted results are formed combinationally from the accumulator register. The narrow result is the 16-bit field at bits 31..16, with optional round-half-up. The wide result is the low 32 bits. Each can clamp to its own range. Extraction uses the format, rounding and saturation bits latched with the last accepted operation. A sticky flag records any accumulator overflow until a clear operation.

Top module: `gmac_unit`

## Requirements
- R1: After reset, the accumulator, the overflow flag and both extracted results are zero, and the latched mode bits are all zero.
- R2: Opcode 2'b00 (load) replaces the accumulator, at the next rising edge, with the 32-bit product extended to 40 bits (sign-extended when signed, zero-extended when unsigned). Load leaves the overflow flag unchanged.
- R3: Opcode 2'b01 adds the extended product to the accumulator, and opcode 2'b10 subtracts it. A new operation can be accepted on every clock cycle.
- R4: When `is_signed`=1, operands and accumulator are two's complement. When it is 0, they are unsigned. The choice is made per operation.
- R5: Opcode 2'b11 zeroes the accumulator and clears the overflow flag at the next rising edge.
- R6: While `in_valid`=0, the accumulator, the flag and the latched mode hold their values, whatever the other inputs are.
- R7: In signed mode with `sat_en`=1, an add or subtract result outside the 40-bit signed range clamps to 0x7F_FFFF_FFFF or 0x80_0000_0000.
- R8: In unsigned mode with `sat_en`=1, an add that carries out clamps to all ones, and a subtract that borrows clamps to 0.
- R9: With `sat_en`=0, an overflowing add or subtract keeps the low 40 bits of the exact result.
- R10: The overflow flag sets on any add or subtract overflow, whether or not saturation is on. Only opcode 2'b11 clears it.
- R11: `res_narrow` is accumulator bits 31..16. With the latched rounding bit set, 0x8000 is added to the accumulator first (round half up).
- R12: With latched saturation, `res_narrow` clamps when the (rounded) value leaves the 32-bit range. In signed mode it clamps to 0x7FFF or 0x8000, and in unsigned mode to 0xFFFF.
- R13: `res_wide` is accumulator bits 31..0. With latched saturation, it clamps to 0x7FFF_FFFF / 0x8000_0000 (signed) or 0xFFFF_FFFF (unsigned) when the guard bits are not an extension of the 32-bit value.
- R14: Both extracted results use the format, rounding and saturation bits captured with the last accepted operation, including a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation accepted this cycle |
| opd_a | input | 16 | First operand |
| opd_b | input | 16 | Second operand |
| opcode | input | 2 | 00 load, 01 add, 10 subtract, 11 clear |
| is_signed | input | 1 | 1 = two's complement, 0 = unsigned |
| rnd_en | input | 1 | Round the narrow result |
| sat_en | input | 1 | Saturate accumulator and results |
| acc_q | output | 40 | Accumulator register |
| res_narrow | output | 16 | Extracted 16-bit result |
| res_wide | output | 32 | Extracted 32-bit result |
| ovf_flag | output | 1 | Sticky accumulator overflow |

## Verification
The bench pushes long runs of the largest products into both signed limits and into the unsigned ceiling and floor. A design with the wrong clamp value, or with a compare of the wrong width, would wrap or stick at a wrong pattern there. It also checks the rounding points 0x8000, -0x8000 and -0x8001, and an accumulator of 0x7FFF_8000 whose rounding crosses the 32-bit boundary. A mishandled carry would show up there as an off-by-one or an unclamped 0x8000. Idle cycles with changed mode bits, and loads right after an overflow, would expose a design that reads live mode inputs or lets load touch the sticky flag.

// File: rtl/gmac_pkg.sv
package gmac_pkg;
   typedef enum logic [1:0] {
      GMAC_LOAD = 2'b00,
      GMAC_ADD  = 2'b01,
      GMAC_SUB  = 2'b10,
      GMAC_CLR  = 2'b11
   } gmac_op_e;

   typedef struct packed {
      logic sgn;
      logic rnd;
      logic sat;
   } gmac_mode_t;
endpackage

// File: rtl/gmac_mult.sv
module gmac_mult #(
   parameter int OP_W    = 16,
   parameter int GUARD_W = 8
) (
   input  logic [OP_W-1:0]             opd_a,
   input  logic [OP_W-1:0]             opd_b,
   input  logic                        is_signed,
   output logic [2*OP_W+GUARD_W-1:0]   prod_ext
);
   localparam int PROD_W = 2 * OP_W;

   logic signed [OP_W:0]     ext_a, ext_b;
   logic signed [PROD_W+1:0] full_p;

   assign ext_a  = {is_signed & opd_a[OP_W-1], opd_a};
   assign ext_b  = {is_signed & opd_b[OP_W-1], opd_b};
   assign full_p = ext_a * ext_b;

   // a signed product fits PROD_W signed bits, an unsigned one PROD_W plain bits
   assign prod_ext = {{GUARD_W{is_signed & full_p[PROD_W-1]}}, full_p[PROD_W-1:0]};
endmodule

// File: rtl/gmac_accum.sv
module gmac_accum #(
   parameter int ACC_W = 40
) (
   input  logic [ACC_W-1:0] acc,
   input  logic [ACC_W-1:0] prod,
   input  logic             sub,
   input  logic             is_signed,
   input  logic             sat_en,
   output logic [ACC_W-1:0] nxt,
   output logic             ovf
);
   localparam logic [ACC_W-1:0] SMAX = {1'b0, {(ACC_W-1){1'b1}}};
   localparam logic [ACC_W-1:0] SMIN = {1'b1, {(ACC_W-1){1'b0}}};

   logic [ACC_W:0] xa, xp, sum;

   assign xa  = {is_signed & acc[ACC_W-1], acc};
   assign xp  = {is_signed & prod[ACC_W-1], prod};
   assign sum = sub ? (xa - xp) : (xa + xp);

   // signed: top two bits disagree; unsigned: carry or borrow out
   assign ovf = is_signed ? (sum[ACC_W] ^ sum[ACC_W-1]) : sum[ACC_W];

   always_comb begin
      if (ovf && sat_en) begin
         if (is_signed) nxt = sum[ACC_W] ? SMIN : SMAX;
         else           nxt = sub ? '0 : '1;
      end else begin
         nxt = sum[ACC_W-1:0];
      end
   end
endmodule

// File: rtl/gmac_extract.sv
module gmac_extract #(
   parameter int ACC_W = 40,
   parameter int OUT_W = 16,
   parameter int LSB   = 16
) (
   input  logic [ACC_W-1:0] acc,
   input  logic             is_signed,
   input  logic             rnd_en,
   input  logic             sat_en,
   output logic [OUT_W-1:0] res
);
   localparam int TOP = LSB + OUT_W;

   if (TOP >= ACC_W) begin : g_bad_top
      $error("gmac_extract: field must lie below the accumulator top bit");
   end

   logic [ACC_W:0] xa, t, hi_s, hi_u;
   logic           in_s, in_u;

   assign xa = {is_signed & acc[ACC_W-1], acc};

   if (LSB > 0) begin : g_rnd
      assign t = xa + ((ACC_W+1)'(rnd_en) << (LSB - 1));
   end else begin : g_trunc
      logic unused_rnd;
      assign unused_rnd = rnd_en;
      assign t = xa;
   end

   assign hi_s = $signed(t) >>> (TOP - 1);
   assign hi_u = t >> TOP;
   assign in_s = (hi_s == '0) || (hi_s == '1);
   assign in_u = (hi_u == '0);

   always_comb begin
      res = t[TOP-1:LSB];
      if (sat_en) begin
         if (is_signed && !in_s)
            res = t[ACC_W] ? {1'b1, {(OUT_W-1){1'b0}}} : {1'b0, {(OUT_W-1){1'b1}}};
         else if (!is_signed && !in_u)
            res = '1;
      end
   end
endmodule

// File: rtl/gmac_unit.sv
module gmac_unit
   import gmac_pkg::*;
#(
   parameter int OP_W    = 16,
   parameter int GUARD_W = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   input  logic [OP_W-1:0]           opd_a,
   input  logic [OP_W-1:0]           opd_b,
   input  logic [1:0]                opcode,
   input  logic                      is_signed,
   input  logic                      rnd_en,
   input  logic                      sat_en,
   output logic [2*OP_W+GUARD_W-1:0] acc_q,
   output logic [OP_W-1:0]           res_narrow,
   output logic [2*OP_W-1:0]         res_wide,
   output logic                      ovf_flag
);
   localparam int PROD_W = 2 * OP_W;
   localparam int ACC_W  = PROD_W + GUARD_W;

   if (OP_W < 2) begin : g_bad_op
      $error("gmac_unit: OP_W must be at least 2");
   end
   if (GUARD_W < 1) begin : g_bad_guard
      $error("gmac_unit: GUARD_W must be at least 1");
   end

   gmac_op_e         op;
   gmac_mode_t       mode_q;
   logic [ACC_W-1:0] prod, acc_nxt;
   logic             ovf_now;

   assign op = gmac_op_e'(opcode);

   gmac_mult #(.OP_W(OP_W), .GUARD_W(GUARD_W)) u_mult (
      .opd_a     (opd_a),
      .opd_b     (opd_b),
      .is_signed (is_signed),
      .prod_ext  (prod)
   );

   gmac_accum #(.ACC_W(ACC_W)) u_accum (
      .acc       (acc_q),
      .prod      (prod),
      .sub       (op == GMAC_SUB),
      .is_signed (is_signed),
      .sat_en    (sat_en),
      .nxt       (acc_nxt),
      .ovf       (ovf_now)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q    <= '0;
         ovf_flag <= 1'b0;
         mode_q   <= '0;
      end else if (in_valid) begin
         mode_q <= '{sgn: is_signed, rnd: rnd_en, sat: sat_en};
         unique case (op)
            GMAC_LOAD: acc_q <= prod;
            GMAC_ADD,
            GMAC_SUB: begin
               acc_q    <= acc_nxt;
               ovf_flag <= ovf_flag | ovf_now;
            end
            GMAC_CLR: begin
               acc_q    <= '0;
               ovf_flag <= 1'b0;
            end
            default: acc_q <= acc_q;
         endcase
      end
   end

   gmac_extract #(.ACC_W(ACC_W), .OUT_W(OP_W), .LSB(OP_W)) u_ext_narrow (
      .acc       (acc_q),
      .is_signed (mode_q.sgn),
      .rnd_en    (mode_q.rnd),
      .sat_en    (mode_q.sat),
      .res       (res_narrow)
   );

   gmac_extract #(.ACC_W(ACC_W), .OUT_W(PROD_W), .LSB(0)) u_ext_wide (
      .acc       (acc_q),
      .is_signed (mode_q.sgn),
      .rnd_en    (mode_q.rnd),
      .sat_en    (mode_q.sat),
      .res       (res_wide)
   );
endmodule

// File: rtl/gmac_unit_chk.sv
module gmac_unit_chk #(
   parameter int OP_W    = 16,
   parameter int GUARD_W = 8
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      in_valid,
   input logic [1:0]                opcode,
   input logic                      is_signed,
   input logic                      sat_en,
   input logic [2*OP_W+GUARD_W-1:0] acc_q,
   input logic [2*OP_W-1:0]         res_wide,
   input logic                      ovf_flag,
   input logic                      m_sgn,
   input logic                      m_sat
);
   localparam int PROD_W = 2 * OP_W;
   localparam int ACC_W  = PROD_W + GUARD_W;

   logic [ACC_W-PROD_W:0] guard_bits;
   logic                  guard_uniform;

   assign guard_bits    = acc_q[ACC_W-1:PROD_W-1];
   assign guard_uniform = (&guard_bits) || !(|guard_bits);

   a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(acc_q) && $stable(ovf_flag));

   a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && opcode == 2'b11 |=> acc_q == '0 && !ovf_flag);

   a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_flag && !(in_valid && opcode == 2'b11) |=> ovf_flag);

   a_r2_load_keeps_flag: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && opcode == 2'b00 |=> ovf_flag == $past(ovf_flag));

   a_r8_floor_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && opcode == 2'b10 && !is_signed && sat_en |=> acc_q <= $past(acc_q));

   a_r13_wide_clamp: assert property (@(posedge clk) disable iff (!rst_n)
      m_sat && m_sgn && !guard_uniform |->
         res_wide == {1'b0, {(PROD_W-1){1'b1}}} || res_wide == {1'b1, {(PROD_W-1){1'b0}}});
endmodule

bind gmac_unit gmac_unit_chk #(.OP_W(OP_W), .GUARD_W(GUARD_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .opcode    (opcode),
   .is_signed (is_signed),
   .sat_en    (sat_en),
   .acc_q     (acc_q),
   .res_wide  (res_wide),
   .ovf_flag  (ovf_flag),
   .m_sgn     (mode_q.sgn),
   .m_sat     (mode_q.sat)
);

// File: tb/gmac_unit_tb.sv
module gmac_unit_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int WDOG       = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [15:0] opd_a = '0, opd_b = '0;
   logic [1:0]  opcode = '0;
   logic        is_signed = 1'b0, rnd_en = 1'b0, sat_en = 1'b0;
   logic [39:0] acc_q;
   logic [15:0] res_narrow;
   logic [31:0] res_wide;
   logic        ovf_flag;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // reference state
   logic [39:0] m_acc = '0;
   bit m_ovf = 0, m_s = 0, m_r = 0, m_sat = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gmac_unit dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opd_a(opd_a), .opd_b(opd_b),
      .opcode(opcode), .is_signed(is_signed), .rnd_en(rnd_en), .sat_en(sat_en),
      .acc_q(acc_q), .res_narrow(res_narrow), .res_wide(res_wide), .ovf_flag(ovf_flag)
   );

   function automatic longint val40(logic [39:0] v, bit s);
      return s ? longint'({{24{v[39]}}, v}) : longint'({24'b0, v});
   endfunction

   function automatic longint mul16(logic [15:0] a, logic [15:0] b, bit s);
      if (s) return longint'($signed(a)) * longint'($signed(b));
      return longint'({48'b0, a}) * longint'({48'b0, b});
   endfunction

   function automatic logic [15:0] exp_narrow();
      longint v = val40(m_acc, m_s);
      longint q;
      logic [63:0] qb;
      if (m_r) v = v + 64'sd32768;
      q = v >>> 16;
      qb = q;
      if (m_sat) begin
         if (m_s && q > 64'sd32767)  return 16'h7FFF;
         if (m_s && q < -64'sd32768) return 16'h8000;
         if (!m_s && q > 64'sd65535) return 16'hFFFF;
      end
      return qb[15:0];
   endfunction

   function automatic logic [31:0] exp_wide();
      longint v = val40(m_acc, m_s);
      logic [63:0] vb = v;
      if (m_sat) begin
         if (m_s && v > 64'sd2147483647)  return 32'h7FFF_FFFF;
         if (m_s && v < -64'sd2147483648) return 32'h8000_0000;
         if (!m_s && v > 64'sd4294967295) return 32'hFFFF_FFFF;
      end
      return vb[31:0];
   endfunction

   task automatic model_apply(logic [15:0] a, logic [15:0] b, logic [1:0] op, bit s, bit r, bit sat);
      longint p = mul16(a, b, s);
      longint va = val40(m_acc, s);
      longint sum;
      logic [63:0] pb, sb;
      bit ov;
      pb = p;
      case (op)
         2'b00: m_acc = pb[39:0];
         2'b01, 2'b10: begin
            sum = (op == 2'b01) ? va + p : va - p;
            sb = sum;
            if (s) ov = (sum > 64'sh7F_FFFF_FFFF) || (sum < -64'sh80_0000_0000);
            else   ov = (sum > 64'shFF_FFFF_FFFF) || (sum < 0);
            if (ov) m_ovf = 1;
            if (ov && sat) begin
               if (s) m_acc = (sum > 0) ? 40'h7F_FFFF_FFFF : 40'h80_0000_0000;
               else   m_acc = (op == 2'b01) ? 40'hFF_FFFF_FFFF : 40'h0;
            end else begin
               m_acc = sb[39:0];
            end
         end
         default: begin
            m_acc = '0;
            m_ovf = 0;
         end
      endcase
      m_s = s; m_r = r; m_sat = sat;
   endtask

   task automatic chk(string tag, string what, logic [63:0] got, logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
      end
   endtask

   task automatic compare(string tag);
      chk(tag, "acc_q", 64'(acc_q), 64'(m_acc));
      chk(tag, "res_narrow", 64'(res_narrow), 64'(exp_narrow()));
      chk(tag, "res_wide", 64'(res_wide), 64'(exp_wide()));
      chk(tag, "ovf_flag", 64'(ovf_flag), 64'(m_ovf));
   endtask

   task automatic step(string tag, bit v, logic [15:0] a, logic [15:0] b,
                       logic [1:0] op, bit s, bit r, bit sat);
      @(negedge clk);
      in_valid = v; opd_a = a; opd_b = b; opcode = op;
      is_signed = s; rnd_en = r; sat_en = sat;
      if (v) model_apply(a, b, op, s, r, sat);
      @(posedge clk);
      #1;
      compare(tag);
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      repeat (WDOG) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog got running expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      compare("R1");
      @(negedge clk);
      rst_n = 1'b1;
      step("R1", 0, 16'h0, 16'h0, 2'b00, 0, 0, 0);

      // R2 R4: signed load of -3*5, unsigned load of 0xFFFF*0xFFFF
      step("R2", 1, 16'hFFFD, 16'd5, 2'b00, 1, 0, 0);
      step("R4", 1, 16'hFFFF, 16'hFFFF, 2'b00, 0, 0, 0);
      step("R4", 1, 16'hFFFF, 16'hFFFF, 2'b00, 1, 0, 0);
      // R3: back-to-back add and subtract
      step("R3", 1, 16'd1000, 16'd300, 2'b01, 1, 0, 0);
      step("R3", 1, 16'h8000, 16'd7, 2'b01, 1, 0, 0);
      step("R3", 1, 16'd12, 16'd12, 2'b10, 1, 0, 0);
      step("R3", 1, 16'd40000, 16'd3, 2'b01, 0, 0, 0);
      // R6: idle cycles with garbage, including a clear opcode
      step("R6", 0, 16'hABCD, 16'h1234, 2'b11, 0, 1, 1);
      step("R6", 0, 16'h5555, 16'h7777, 2'b00, 1, 0, 1);
      // R5: clear
      step("R5", 1, 16'h1, 16'h1, 2'b11, 1, 0, 0);

      // R7: signed ceiling with saturation, 2^30 per product
      step("R7", 1, 16'h8000, 16'h8000, 2'b00, 1, 0, 1);
      for (int i = 0; i < 520; i++) step("R7", 1, 16'h8000, 16'h8000, 2'b01, 1, 0, 1);
      // R2 R10: load after overflow keeps flag, further ops keep it
      step("R2", 1, 16'd3, 16'd4, 2'b00, 1, 0, 1);
      step("R10", 1, 16'd3, 16'd4, 2'b01, 1, 0, 1);
      step("R10", 0, 16'd3, 16'd4, 2'b11, 1, 0, 1);
      step("R5", 1, 16'd0, 16'd0, 2'b11, 1, 0, 1);
      // R7: signed floor by repeated subtract
      for (int i = 0; i < 520; i++) step("R7", 1, 16'h8000, 16'h8000, 2'b10, 1, 0, 1);
      step("R5", 1, 16'd0, 16'd0, 2'b11, 1, 0, 0);
      // R9: wrap without saturation
      for (int i = 0; i < 516; i++) step("R9", 1, 16'h8000, 16'h8000, 2'b01, 1, 0, 0);
      step("R5", 1, 16'd0, 16'd0, 2'b11, 0, 0, 1);
      // R8: unsigned floor and ceiling
      step("R8", 1, 16'd1, 16'd1, 2'b10, 0, 0, 1);
      step("R5", 1, 16'd0, 16'd0, 2'b11, 0, 0, 1);
      for (int i = 0; i < 260; i++) step("R8", 1, 16'hFFFF, 16'hFFFF, 2'b01, 0, 0, 1);
      step("R5", 1, 16'd0, 16'd0, 2'b11, 0, 0, 0);

      // R11: rounding points
      step("R11", 1, 16'h0080, 16'h0100, 2'b00, 1, 1, 0);
      step("R11", 1, 16'h0080, 16'h0100, 2'b00, 1, 0, 0);
      step("R11", 1, 16'h7FFF, 16'h0001, 2'b00, 1, 1, 0);
      step("R11", 1, 16'h8000, 16'h0001, 2'b00, 1, 1, 0);
      step("R11", 1, 16'hFFFD, 16'h2AAB, 2'b00, 1, 1, 0);
      // R12: 0x7FFF_8000 rounds past the 32-bit signed range
      step("R12", 1, 16'hFFFF, 16'h8000, 2'b00, 0, 0, 0);
      step("R12", 1, 16'h0, 16'h0, 2'b01, 1, 1, 1);
      step("R12", 1, 16'h0, 16'h0, 2'b01, 1, 1, 0);
      step("R12", 1, 16'hFFFF, 16'hFFFF, 2'b01, 0, 1, 1);
      // R14: idle with changed mode bits leaves extraction alone
      step("R14", 0, 16'h0, 16'h0, 2'b01, 1, 0, 1);
      step("R14", 1, 16'h0, 16'h0, 2'b01, 1, 0, 1);
      // R13: wide clamp with large signed accumulator
      step("R13", 1, 16'h8000, 16'h8000, 2'b00, 1, 0, 1);
      step("R13", 1, 16'h8000, 16'h8000, 2'b01, 1, 0, 1);
      step("R13", 1, 16'h0, 16'h0, 2'b01, 1, 0, 0);
      step("R13", 1, 16'h8000, 16'h7FFF, 2'b10, 1, 0, 1);

      // mixed traffic
      for (int i = 0; i < 2000; i++) begin
         logic [31:0] rv = $urandom;
         step("R3", rv[0] | rv[1], 16'($urandom), 16'($urandom),
              (rv[7:4] == 4'd0) ? 2'b11 : rv[3:2], rv[8], rv[9], rv[10]);
      end

      done = 1;
      summary();
      $finish;
   end
endmodule